// File: doc/BRIEF.md
# Vector element swizzle unit

This unit rebuilds a short vector of up to four elements. The lanes are named x, y, z and w and sit at indices 0 to 3. A packed selector word controls the rebuild. Each destination lane has its own 3-bit code. That code picks one of two things:

- a lane of the first source vector, or
- an upper-half choice, whose meaning depends on the operating mode.

In two-source mode, the upper-half codes pick lanes of a second source vector. In single-source mode, they produce fixed constants. Integer mode and floating-point mode each have their own set of constants. The selector is decoded the same way whether it came from an immediate or from a register operand.

The active group length runs from 1 to 4 lanes. Only the selector fields of active lanes carry meaning. If any field belonging to an inactive lane is nonzero, the operation is treated as an illegal selector. The unit then raises a trap flag and writes no result.

Results, a per-lane valid mask and the trap flag are registered once. They appear one clock after the input strobe.

Top module: `vec_swizzle_unit`

## Requirements
- R1: A code below 4 (bit 2 clear) copies lane `code[1:0]` of `src_a` into the destination lane. This holds even when that source lane index is at or above the group length. Lane i occupies bits `[i*ELEM_W +: ELEM_W]`, and the selector field of destination lane i occupies `sel[3*i +: 3]`.
- R2: With `two_src` high, a code of 4 to 7 copies lane `code[1:0]` of `src_b`.
- R3: With `two_src` low and `fp_mode` low, codes 4, 5, 6 and 7 produce the following constants:
  - 0
  - 1
  - the signed maximum (0 followed by all ones)
  - all ones
- R4: With `two_src` low and `fp_mode` high, codes 4, 5, 6 and 7 produce the binary floating-point values 0.0, 1.0, -1.0 and 0.5 at the element width. For 32-bit elements these are 0x00000000, 0x3F800000, 0xBF800000 and 0x3F000000.
- R5: The group length is `len_m1 + 1`. In `out_lane_en`, bit i is set exactly when i <= `len_m1`. Output lanes above the group are zero.
- R6: Whenever any selector field of a lane above `len_m1` is nonzero, `out_trap` is 1 and both `out_data` and `out_lane_en` are 0. With a full group (`len_m1` = 3) the unit never traps.
- R7: `out_valid` is high exactly in the cycle after an `in_valid` cycle. Without `in_valid`, `out_data`, `out_lane_en` and `out_trap` keep their values.
- R8: Synchronous reset clears `out_valid`, `out_data`, `out_lane_en` and `out_trap`.
- R9: In two-source mode `fp_mode` has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input strobe |
| two_src | input | 1 | 1: upper codes pick `src_b` lanes |
| fp_mode | input | 1 | 1: single-source constants are floating-point |
| len_m1 | input | 2 | Group length minus one |
| sel | input | 12 | Packed 3-bit selector per destination lane |
| src_a | input | 128 | First source vector, lane 0 in the low bits |
| src_b | input | 128 | Second source vector |
| out_valid | output | 1 | Result strobe |
| out_data | output | 128 | Swizzled vector |
| out_lane_en | output | 4 | Per-lane valid mask |
| out_trap | output | 1 | Illegal-selector trap |

## Verification
The selector patterns cover identity, reversal, a two-source mix and all four upper codes under each mode. Together they separate first-source lanes, second-source lanes, integer constants and floating-point constants, and they show that `fp_mode` is dropped when two sources are in use.

Short groups are run with set bits both below and above the group boundary. These runs tell a legal short selector apart from a trapping one, and a lane that is zeroed apart from a lane that is selected. One of them reads a source lane that lies beyond the group.

Directed sequences hold the inputs idle and assert reset in the middle of an operation. They separate the latency and hold behaviour from the reset behaviour.

// File: rtl/swz_pkg.sv
package swz_pkg;
  localparam int CODE_W = 3;

  typedef enum logic [1:0] {
    PICK_A    = 2'd0,
    PICK_B    = 2'd1,
    PICK_KINT = 2'd2,
    PICK_KFP  = 2'd3
  } pick_e;

  // Meaning of one 3-bit lane code under the current mode.
  function automatic pick_e classify(input logic [CODE_W-1:0] code,
                                     input logic two_src,
                                     input logic fp_mode);
    if (!code[2]) return PICK_A;
    if (two_src) return PICK_B;
    return fp_mode ? PICK_KFP : PICK_KINT;
  endfunction
endpackage

// File: rtl/swz_const_gen.sv
module swz_const_gen #(
  parameter int ELEM_W = 32
) (
  input  logic [1:0]        idx,
  input  logic              fp_mode,
  output logic [ELEM_W-1:0] value
);
  // Exponent and mantissa widths for binary16/32/64; other widths use the 32-bit split.
  localparam int EXP_W = (ELEM_W == 16) ? 5 : ((ELEM_W == 64) ? 11 : 8);
  localparam int MAN_W = ELEM_W - 1 - EXP_W;
  localparam logic [EXP_W-1:0] BIAS = {1'b0, {(EXP_W-1){1'b1}}};

  function automatic logic [ELEM_W-1:0] int_k(input logic [1:0] k);
    case (k)
      2'd0:    return '0;
      2'd1:    return ELEM_W'(1);
      2'd2:    return {1'b0, {(ELEM_W-1){1'b1}}};
      default: return '1;
    endcase
  endfunction

  function automatic logic [ELEM_W-1:0] fp_k(input logic [1:0] k);
    logic [EXP_W-1:0] half_exp;
    half_exp = BIAS - EXP_W'(1);
    case (k)
      2'd0:    return '0;
      2'd1:    return {1'b0, BIAS, {MAN_W{1'b0}}};
      2'd2:    return {1'b1, BIAS, {MAN_W{1'b0}}};
      default: return {1'b0, half_exp, {MAN_W{1'b0}}};
    endcase
  endfunction

  assign value = fp_mode ? fp_k(idx) : int_k(idx);
endmodule

// File: rtl/swz_lane_mux.sv
module swz_lane_mux
  import swz_pkg::*;
#(
  parameter int ELEM_W = 32,
  parameter int LANES  = 4
) (
  input  logic [CODE_W-1:0]       code,
  input  logic                    two_src,
  input  logic                    fp_mode,
  input  logic [LANES*ELEM_W-1:0] src_a,
  input  logic [LANES*ELEM_W-1:0] src_b,
  output logic [ELEM_W-1:0]       lane_out,
  output pick_e                   kind
);
  logic [ELEM_W-1:0] a_lane;
  logic [ELEM_W-1:0] b_lane;
  logic [ELEM_W-1:0] k_val;

  swz_const_gen #(.ELEM_W(ELEM_W)) u_kgen (
    .idx     (code[1:0]),
    .fp_mode (fp_mode),
    .value   (k_val)
  );

  always_comb begin
    a_lane = '0;
    b_lane = '0;
    for (int j = 0; j < LANES; j++) begin
      if (code[1:0] == 2'(j)) begin
        a_lane = src_a[j*ELEM_W +: ELEM_W];
        b_lane = src_b[j*ELEM_W +: ELEM_W];
      end
    end
  end

  assign kind = classify(code, two_src, fp_mode);

  always_comb begin
    case (kind)
      PICK_A:  lane_out = a_lane;
      PICK_B:  lane_out = b_lane;
      default: lane_out = k_val;
    endcase
  end
endmodule

// File: rtl/swz_sel_check.sv
module swz_sel_check
  import swz_pkg::*;
#(
  parameter int LANES = 4,
  parameter int LEN_W = 2
) (
  input  logic [LANES*CODE_W-1:0] sel,
  input  logic [LEN_W-1:0]        len_m1,
  output logic [LANES-1:0]        active,
  output logic [LANES-1:0]        stray,
  output logic                    trap
);
  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      active[i] = (i <= int'(len_m1));
      stray[i]  = !active[i] && (sel[i*CODE_W +: CODE_W] != '0);
    end
  end

  assign trap = |stray;
endmodule

// File: rtl/vec_swizzle_unit.sv
module vec_swizzle_unit
  import swz_pkg::*;
#(
  parameter int ELEM_W = 32,
  parameter int LANES  = 4,
  localparam int LEN_W = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int VEC_W = LANES * ELEM_W,
  localparam int SEL_W = LANES * CODE_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             two_src,
  input  logic             fp_mode,
  input  logic [LEN_W-1:0] len_m1,
  input  logic [SEL_W-1:0] sel,
  input  logic [VEC_W-1:0] src_a,
  input  logic [VEC_W-1:0] src_b,
  output logic             out_valid,
  output logic [VEC_W-1:0] out_data,
  output logic [LANES-1:0] out_lane_en,
  output logic             out_trap
);
  logic [LANES-1:0] active;
  logic [LANES-1:0] stray;
  logic             sel_trap;
  logic [VEC_W-1:0] picked;
  logic [VEC_W-1:0] gated;
  pick_e            lane_kind [LANES];

  swz_sel_check #(.LANES(LANES), .LEN_W(LEN_W)) u_chk (
    .sel    (sel),
    .len_m1 (len_m1),
    .active (active),
    .stray  (stray),
    .trap   (sel_trap)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    swz_lane_mux #(.ELEM_W(ELEM_W), .LANES(LANES)) u_mux (
      .code     (sel[i*CODE_W +: CODE_W]),
      .two_src  (two_src),
      .fp_mode  (fp_mode),
      .src_a    (src_a),
      .src_b    (src_b),
      .lane_out (picked[i*ELEM_W +: ELEM_W]),
      .kind     (lane_kind[i])
    );
    assign gated[i*ELEM_W +: ELEM_W] = active[i] ? picked[i*ELEM_W +: ELEM_W] : '0;

    AST_PICK_A_RAW: assert property (@(posedge clk) disable iff (rst)
      (in_valid && !sel_trap && active[i] && lane_kind[i] == PICK_A) |=>
        out_data[i*ELEM_W +: ELEM_W] == $past(src_a[int'(sel[i*CODE_W +: 2])*ELEM_W +: ELEM_W])); // R1
    AST_PICK_B_RAW: assert property (@(posedge clk) disable iff (rst)
      (in_valid && !sel_trap && active[i] && two_src && sel[i*CODE_W+2]) |=>
        out_data[i*ELEM_W +: ELEM_W] == $past(src_b[int'(sel[i*CODE_W +: 2])*ELEM_W +: ELEM_W])); // R2
    AST_UMAX_ONES: assert property (@(posedge clk) disable iff (rst)
      (in_valid && !sel_trap && active[i] && lane_kind[i] == PICK_KINT && sel[i*CODE_W +: 2] == 2'b11) |=>
        out_data[i*ELEM_W +: ELEM_W] == '1); // R3
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_data    <= '0;
      out_lane_en <= '0;
      out_trap    <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_trap    <= sel_trap;
        out_lane_en <= sel_trap ? '0 : active;
        out_data    <= sel_trap ? '0 : gated;
      end
    end
  end

  AST_VALID_NEXT: assert property (@(posedge clk) disable iff (rst) in_valid |=> out_valid); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst) !in_valid |=> (!out_valid && $stable(out_data) && $stable(out_trap))); // R7
  AST_TRAP_SILENT: assert property (@(posedge clk) disable iff (rst) (out_valid && out_trap) |-> (out_data == '0 && out_lane_en == '0)); // R6
  AST_FULL_NO_TRAP: assert property (@(posedge clk) disable iff (rst) (in_valid && len_m1 == LEN_W'(LANES-1)) |=> !out_trap); // R6
  AST_MASK_PREFIX: assert property (@(posedge clk) disable iff (rst) (out_valid && !out_trap) |-> (out_lane_en[0] && ((out_lane_en & (out_lane_en + 1'b1)) == '0))); // R5
  AST_RESET_CLR: assert property (@(posedge clk) rst |=> (!out_valid && out_data == '0 && !out_trap)); // R8
endmodule

// File: tb/sim_vec_swizzle_unit.sv
module sim_vec_swizzle_unit;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic         two_src;
    logic         fp;
    logic [1:0]   len_m1;
    logic [11:0]  sel;
    logic [127:0] exp_data;
    logic [3:0]   exp_mask;
    logic         exp_trap;
  } vec_t;

  localparam logic [127:0] SRC_A = {32'h44444444, 32'h33333333, 32'h22222222, 32'h11111111};
  localparam logic [127:0] SRC_B = {32'h88888888, 32'h77777777, 32'h66666666, 32'h55555555};
  localparam int NV = 12;

  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 2'd3, 12'h688, {32'h44444444, 32'h33333333, 32'h22222222, 32'h11111111}, 4'hF, 1'b0},
    '{1'b0, 1'b0, 2'd3, 12'h053, {32'h11111111, 32'h22222222, 32'h33333333, 32'h44444444}, 4'hF, 1'b0},
    '{1'b1, 1'b0, 2'd3, 12'h57C, {32'h33333333, 32'h66666666, 32'h88888888, 32'h55555555}, 4'hF, 1'b0},
    '{1'b0, 1'b0, 2'd3, 12'hFAC, {32'hFFFFFFFF, 32'h7FFFFFFF, 32'h00000001, 32'h00000000}, 4'hF, 1'b0},
    '{1'b0, 1'b1, 2'd3, 12'hFAC, {32'h3F000000, 32'hBF800000, 32'h3F800000, 32'h00000000}, 4'hF, 1'b0},
    '{1'b1, 1'b1, 2'd3, 12'hFAC, {32'h88888888, 32'h77777777, 32'h66666666, 32'h55555555}, 4'hF, 1'b0},
    '{1'b0, 1'b0, 2'd1, 12'h033, {32'h0, 32'h0, 32'h7FFFFFFF, 32'h44444444}, 4'h3, 1'b0},
    '{1'b0, 1'b0, 2'd0, 12'h008, 128'h0, 4'h0, 1'b1},
    '{1'b0, 1'b0, 2'd2, 12'h800, 128'h0, 4'h0, 1'b1},
    '{1'b0, 1'b0, 2'd3, 12'h800, {32'h00000000, 32'h11111111, 32'h11111111, 32'h11111111}, 4'hF, 1'b0},
    '{1'b0, 1'b1, 2'd0, 12'h005, {32'h0, 32'h0, 32'h0, 32'h3F800000}, 4'h1, 1'b0},
    '{1'b1, 1'b0, 2'd2, 12'h107, {32'h0, 32'h55555555, 32'h11111111, 32'h88888888}, 4'h7, 1'b0}
  };

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic         two_src = 1'b0;
  logic         fp_mode = 1'b0;
  logic [1:0]   len_m1 = 2'd0;
  logic [11:0]  sel = '0;
  logic [127:0] src_a = SRC_A;
  logic [127:0] src_b = SRC_B;
  logic         out_valid;
  logic [127:0] out_data;
  logic [3:0]   out_lane_en;
  logic         out_trap;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  vec_swizzle_unit u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .two_src(two_src), .fp_mode(fp_mode),
    .len_m1(len_m1), .sel(sel), .src_a(src_a), .src_b(src_b),
    .out_valid(out_valid), .out_data(out_data), .out_lane_en(out_lane_en), .out_trap(out_trap)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input string what, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic string tag_of(input int k);
    case (k)
      0, 1, 6: return "R1";
      2, 11:   return "R2";
      3:       return "R3";
      4, 10:   return "R4";
      5:       return "R9";
      7, 8, 9: return "R6";
      default: return "R5";
    endcase
  endfunction

  task automatic drive(input vec_t v);
    two_src = v.two_src;
    fp_mode = v.fp;
    len_m1  = v.len_m1;
    sel     = v.sel;
    in_valid = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R8", "reset valid", 128'(out_valid), 128'(0));
    chk("R8", "reset data", out_data, 128'h0);
    chk("R8", "reset mask+trap", 128'({out_lane_en, out_trap}), 128'(0));
    rst = 1'b0;

    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      drive(VECS[k]);
      @(negedge clk);
      in_valid = 1'b0;
      chk(tag_of(k), "data", out_data, VECS[k].exp_data);
      chk(tag_of(k), "valid/mask/trap", 128'({out_valid, out_lane_en, out_trap}),
          128'({1'b1, VECS[k].exp_mask, VECS[k].exp_trap}));
    end

    // R7: idle cycles with changed inputs leave the result in place
    @(negedge clk);
    drive(VECS[0]);
    @(negedge clk);
    in_valid = 1'b0;
    sel = 12'h053;
    len_m1 = 2'd0;
    chk("R7", "one-cycle latency", 128'(out_valid), 128'(1));
    @(negedge clk);
    chk("R7", "valid drops", 128'(out_valid), 128'(0));
    chk("R7", "held data", out_data, VECS[0].exp_data);
    chk("R7", "held mask", 128'({out_lane_en, out_trap}), 128'({4'hF, 1'b0}));

    // R8: reset wins over a concurrent input strobe
    drive(VECS[3]);
    rst = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R8", "mid-run reset valid", 128'(out_valid), 128'(0));
    chk("R8", "mid-run reset data", out_data, 128'h0);
    rst = 1'b0;

    // R6: trap followed by a legal operation recovers
    @(negedge clk);
    drive(VECS[7]);
    @(negedge clk);
    drive(VECS[1]);
    chk("R6", "trap flag", 128'(out_trap), 128'(1));
    @(negedge clk);
    in_valid = 1'b0;
    chk("R6", "recovered data", out_data, VECS[1].exp_data);
    chk("R6", "recovered trap", 128'(out_trap), 128'(0));

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R7 watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule